// File: doc/BRIEF.md
# Ratioed Clock Sync Pulse Generator

This block runs entirely on the fast core clock. It produces the enable pulses that let data cross safely between the core clock and clocks that are locked to it at a fixed ratio. The memory-side clock runs at a ratio of N:4, with N selectable from 8 to 21. Two I/O clocks, one at double rate and one at single rate, divide the core clock by integer factors. Each pulse marks the one fast cycle in each slow cycle where a transfer is free of setup and hold risk.

Inside each pattern's repeating super-period, the positions come from a per-ratio phase table. A single synchronous aligned reset sets phase 0, the nominal alignment of the fast and slow clocks. Each pulse reaches the point of use through a fixed chain of distribution registers. The generators therefore start their counters advanced by that latency, so that each pulse arrives on its intended phase. A small launch/capture datapath shows how the enables are used. The fast-to-slow launch register loads only in enabled cycles, and so does the slow-to-fast capture register.

Top module: `sync_pulse_gen`

## Requirements
- R1: While the asynchronous active-low reset `rst_n` is low, every enable output and both data registers read 0, and they go to 0 at once when that reset is asserted.
- R2: Rising edges at which `align_rst_n` is sampled high are numbered K = 1, 2, and so on. The cycle after edge K has phase q = (K-1) mod N. For ratio N, the memory enable is high at exactly these phases of each N-cycle super-period:
  - N=8: 1,3,5,7
  - N=9: 1,3,6,8
  - N=10: 1,4,6,9
  - N=11: 1,4,7,10
  - N=12: 1,4,7,10
  - N=13: 2,5,8,11
  - N=14: 2,5,9,12
  - N=15: 2,6,9,13
  - N=16: 2,6,10,14
  - N=17: 2,6,11,15
  - N=18: 2,7,11,16
  - N=19: 2,7,12,17
  - N=20: 2,7,12,17
  - N=21: 3,8,13,18
- R3: The pulses pass through PIPE_STAGES+USE_STAGES registers (default 7+1 = 8 = LAT), and the generators are pre-advanced by that amount. All enables therefore stay low after edges K = 1 to LAT-1 of each release, and from edge K = LAT onward they follow their phase rules exactly.
- R4: For a valid ratio, the memory enable pulses exactly 8 times in any 2N consecutive cycles after the pipeline has filled (once per slow cycle), and it is never high in two consecutive cycles.
- R5: The fast-to-slow enable `mem_f2s_en` and the slow-to-fast enable `mem_s2f_en` are driven from one source and are equal in every cycle.
- R6: `io2x_sync_en` is high when (K-1) mod IO2X_DIV = 0, and `io_sync_en` is high when (K-1) mod IO_DIV = 0 (defaults 2 and 4), subject to R3. Both are independent of `ratio_n`.
- R7: `ratio_n` is latched only while `align_rst_n` is low. A change while it is high has no effect on the pulse pattern until the aligned reset is applied and released again.
- R8: A ratio outside 8 to 21 produces no memory enable pulses, while the I/O enables continue per R6.
- R9: `f2s_launch_q` loads `f2s_din` at the rising edge that ends a cycle with `mem_f2s_en` high, and otherwise holds its value.
- R10: `s2f_capture_q` loads `s2f_din` at the rising edge that ends a cycle with `mem_s2f_en` high, and otherwise holds its value.
- R11: A rising edge that samples `align_rst_n` low clears the distribution pipeline, so all enables are low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| align_rst_n | input | 1 | Synchronous aligned reset; low holds phase and latches the ratio |
| ratio_n | input | 5 | Ratio numerator N of the N:4 memory-side clock |
| f2s_din | input | DATA_W | Data to launch toward the slow domain |
| s2f_din | input | DATA_W | Data arriving from the slow domain |
| mem_f2s_en | output | 1 | Fast-to-slow transfer enable for the memory-side clock |
| mem_s2f_en | output | 1 | Slow-to-fast transfer enable for the memory-side clock |
| io2x_sync_en | output | 1 | Transfer enable for the double-rate I/O clock (both directions) |
| io_sync_en | output | 1 | Transfer enable for the single-rate I/O clock (both directions) |
| f2s_launch_q | output | DATA_W | Launch register toward the slow domain |
| s2f_capture_q | output | DATA_W | Capture register from the slow domain |

## Verification
Three classes of ratio are exercised:
- Odd ratios (9, 11, 13, 21) give four unevenly spaced positions over a full N-cycle period.
- Even ratios not divisible by four (10, 14) repeat with two positions per half period.
- Multiples of four (8, 12, 16, 20) repeat one position every N/4 cycles.

These three classes separate a generator whose counter wraps at the reduced period from one that wraps at N. Each release also checks the first LAT cycles, which exposes a wrong pre-advance as a phase shift or as a pulse leaking out of the flushed pipeline. Other runs cover a ratio change while running, out-of-range ratios and an asynchronous reset mid-pattern. Together they show that the latched ratio and the reset paths govern the pattern, and that the live input does not.

// File: rtl/sync_pulse_pkg.sv
package sync_pulse_pkg;

  localparam int RATIO_W = 5;
  localparam int PH_W    = 5;
  localparam int MAX_POS = 4;

  typedef struct packed {
    logic                        valid;
    logic [PH_W-1:0]             period;
    logic [2:0]                  npos;
    logic [MAX_POS-1:0][PH_W-1:0] pos;
  } ratio_info_t;

  // Reduced repeat period and pulse phases inside it for each N:4 ratio.
  function automatic ratio_info_t lookup_ratio(input logic [RATIO_W-1:0] n);
    ratio_info_t r;
    r.valid  = 1'b1;
    r.period = n;
    r.npos   = 3'd4;
    r.pos    = '0;
    case (n)
      5'd8:  begin r.period = 5'd2; r.npos = 3'd1; r.pos[0] = 5'd1; end
      5'd9:  r.pos = {5'd8, 5'd6, 5'd3, 5'd1};
      5'd10: begin r.period = 5'd5; r.npos = 3'd2; r.pos[1] = 5'd4; r.pos[0] = 5'd1; end
      5'd11: r.pos = {5'd10, 5'd7, 5'd4, 5'd1};
      5'd12: begin r.period = 5'd3; r.npos = 3'd1; r.pos[0] = 5'd1; end
      5'd13: r.pos = {5'd11, 5'd8, 5'd5, 5'd2};
      5'd14: begin r.period = 5'd7; r.npos = 3'd2; r.pos[1] = 5'd5; r.pos[0] = 5'd2; end
      5'd15: r.pos = {5'd13, 5'd9, 5'd6, 5'd2};
      5'd16: begin r.period = 5'd4; r.npos = 3'd1; r.pos[0] = 5'd2; end
      5'd17: r.pos = {5'd15, 5'd11, 5'd6, 5'd2};
      5'd18: begin r.period = 5'd9; r.npos = 3'd2; r.pos[1] = 5'd7; r.pos[0] = 5'd2; end
      5'd19: r.pos = {5'd17, 5'd12, 5'd7, 5'd2};
      5'd20: begin r.period = 5'd5; r.npos = 3'd1; r.pos[0] = 5'd2; end
      5'd21: r.pos = {5'd18, 5'd13, 5'd8, 5'd3};
      default: begin r.valid = 1'b0; r.period = 5'd1; r.npos = 3'd0; end
    endcase
    return r;
  endfunction

  // Small modulo by repeated subtraction; divisor is at least 1.
  function automatic logic [PH_W-1:0] mod_small(input int unsigned v,
                                                input logic [PH_W-1:0] p);
    int unsigned acc;
    acc = v;
    for (int i = 0; i < 64; i++) begin
      if (acc >= 32'(p)) acc = acc - 32'(p);
    end
    return PH_W'(acc);
  endfunction

endpackage

// File: rtl/ratio_phase_gen.sv
module ratio_phase_gen
  import sync_pulse_pkg::*;
#(
  parameter int LAT = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               align_rst_n,
  input  logic [RATIO_W-1:0] ratio_n,
  output logic               hit,
  output logic               ratio_ok
);

  ratio_info_t        info_in;
  ratio_info_t        info_q;
  logic [RATIO_W-1:0] ratio_q, ratio_d;
  logic [PH_W-1:0]    cnt_q, cnt_d;
  logic [PH_W-1:0]    start_ph;
  logic [PH_W-1:0]    last_ph;

  // Next state: ratio latch and pre-advanced phase counter.
  always_comb begin
    info_in  = lookup_ratio(ratio_n);
    info_q   = lookup_ratio(ratio_q);
    start_ph = mod_small(32'(LAT - 1), info_in.period);
    last_ph  = info_q.period - 1'b1;
    ratio_d  = align_rst_n ? ratio_q : ratio_n;
    if (!align_rst_n) begin
      cnt_d = start_ph;
    end else if (cnt_q >= last_ph) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  // Position match against the table entries in use.
  always_comb begin
    hit = 1'b0;
    for (int i = 0; i < MAX_POS; i++) begin
      if ((i < int'(info_q.npos)) && (cnt_q == info_q.pos[i])) begin
        hit = info_q.valid;
      end
    end
  end

  assign ratio_ok = info_q.valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ratio_q <= '0;
      cnt_q   <= '0;
    end else begin
      ratio_q <= ratio_d;
      cnt_q   <= cnt_d;
    end
  end

  // R2
  cnt_in_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    align_rst_n |-> (cnt_q < info_q.period));

  // R7
  ratio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    align_rst_n |=> $stable(ratio_q));

endmodule

// File: rtl/int_phase_gen.sv
module int_phase_gen #(
  parameter int DIV = 2,
  parameter int LAT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic align_rst_n,
  output logic hit
);

  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] START = CW'((LAT - 1) % DIV);
  localparam logic [CW-1:0] LAST  = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (!align_rst_n) begin
      cnt_d = START;
    end else if (cnt_q == LAST) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  assign hit = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  // R6
  io_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (align_rst_n && hit) |=> !hit);

endmodule

// File: rtl/dist_pipe.sv
module dist_pipe #(
  parameter int DEPTH = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic align_rst_n,
  input  logic din,
  output logic dout
);

  logic [DEPTH-1:0] stg_q, stg_d;

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
      if (g == 0) begin : g_first
        assign stg_d[g] = align_rst_n & din;
      end else begin : g_rest
        assign stg_d[g] = align_rst_n & stg_q[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= '0;
    end else begin
      stg_q <= stg_d;
    end
  end

  assign dout = stg_q[DEPTH-1];

  // R11
  flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !align_rst_n |=> !dout);

endmodule

// File: rtl/xfer_demo.sv
module xfer_demo #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              f2s_en,
  input  logic [DATA_W-1:0] f2s_din,
  input  logic              s2f_en,
  input  logic [DATA_W-1:0] s2f_din,
  output logic [DATA_W-1:0] launch_q,
  output logic [DATA_W-1:0] capt_q
);

  logic [DATA_W-1:0] launch_d, capt_d;

  always_comb begin
    launch_d = f2s_en ? f2s_din : launch_q;
    capt_d   = s2f_en ? s2f_din : capt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      launch_q <= '0;
      capt_q   <= '0;
    end else begin
      launch_q <= launch_d;
      capt_q   <= capt_d;
    end
  end

  // R9
  launch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !f2s_en |=> $stable(launch_q));

  // R10
  capt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s2f_en |=> (capt_q == $past(s2f_din)));

endmodule

// File: rtl/sync_pulse_gen.sv
module sync_pulse_gen
  import sync_pulse_pkg::*;
#(
  parameter int PIPE_STAGES = 7,
  parameter int USE_STAGES  = 1,
  parameter int IO2X_DIV    = 2,
  parameter int IO_DIV      = 4,
  parameter int DATA_W      = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               align_rst_n,
  input  logic [RATIO_W-1:0] ratio_n,
  input  logic [DATA_W-1:0]  f2s_din,
  input  logic [DATA_W-1:0]  s2f_din,
  output logic               mem_f2s_en,
  output logic               mem_s2f_en,
  output logic               io2x_sync_en,
  output logic               io_sync_en,
  output logic [DATA_W-1:0]  f2s_launch_q,
  output logic [DATA_W-1:0]  s2f_capture_q
);

  localparam int LAT    = PIPE_STAGES + USE_STAGES;
  localparam int N_IO   = 2;
  localparam int IO_DIVS [N_IO] = '{IO2X_DIV, IO_DIV};

  logic            rst_meta_q, rst_sync_n;
  logic            mem_hit, mem_en, ratio_ok;
  logic [N_IO-1:0] io_hit, io_en;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  ratio_phase_gen #(.LAT(LAT)) u_mem_gen (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .align_rst_n (align_rst_n),
    .ratio_n     (ratio_n),
    .hit         (mem_hit),
    .ratio_ok    (ratio_ok)
  );

  dist_pipe #(.DEPTH(LAT)) u_mem_pipe (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .align_rst_n (align_rst_n),
    .din         (mem_hit),
    .dout        (mem_en)
  );

  generate
    for (genvar g = 0; g < N_IO; g++) begin : g_io
      int_phase_gen #(.DIV(IO_DIVS[g]), .LAT(LAT)) u_gen (
        .clk         (clk),
        .rst_n       (rst_sync_n),
        .align_rst_n (align_rst_n),
        .hit         (io_hit[g])
      );
      dist_pipe #(.DEPTH(LAT)) u_pipe (
        .clk         (clk),
        .rst_n       (rst_sync_n),
        .align_rst_n (align_rst_n),
        .din         (io_hit[g]),
        .dout        (io_en[g])
      );
    end
  endgenerate

  assign mem_f2s_en   = mem_en;
  assign mem_s2f_en   = mem_en;
  assign io2x_sync_en = io_en[0];
  assign io_sync_en   = io_en[1];

  xfer_demo #(.DATA_W(DATA_W)) u_xfer (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .f2s_en   (mem_en),
    .f2s_din  (f2s_din),
    .s2f_en   (mem_en),
    .s2f_din  (s2f_din),
    .launch_q (f2s_launch_q),
    .capt_q   (s2f_capture_q)
  );

  // R4
  mem_spacing_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mem_f2s_en |=> !mem_f2s_en);

  // R8
  mem_valid_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mem_f2s_en |-> ratio_ok);

endmodule

// File: tb/sync_pulse_gen_test.sv
module sync_pulse_gen_test;

  localparam int LAT    = 8;
  localparam int DATA_W = 8;

  logic              clk;
  logic              rst_n;
  logic              align_rst_n;
  logic [4:0]        ratio_n;
  logic [DATA_W-1:0] f2s_din, s2f_din;
  logic              mem_f2s_en, mem_s2f_en, io2x_sync_en, io_sync_en;
  logic [DATA_W-1:0] f2s_launch_q, s2f_capture_q;

  int checks = 0;
  int fails  = 0;
  int K      = 0;
  logic [DATA_W-1:0] exp_launch = '0;
  logic [DATA_W-1:0] exp_capt   = '0;

  sync_pulse_gen #(.PIPE_STAGES(7), .USE_STAGES(1), .IO2X_DIV(2), .IO_DIV(4),
                   .DATA_W(DATA_W)) uut (
    .clk(clk), .rst_n(rst_n), .align_rst_n(align_rst_n), .ratio_n(ratio_n),
    .f2s_din(f2s_din), .s2f_din(s2f_din),
    .mem_f2s_en(mem_f2s_en), .mem_s2f_en(mem_s2f_en),
    .io2x_sync_en(io2x_sync_en), .io_sync_en(io_sync_en),
    .f2s_launch_q(f2s_launch_q), .s2f_capture_q(s2f_capture_q)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s K=%0d actual=%0h expected=%0h", tag, what, K, act, exp);
    end
  endtask

  function automatic int abs_pos(input int n, input int i);
    int p [4];
    case (n)
      8:  p = '{1, 3, 5, 7};
      9:  p = '{1, 3, 6, 8};
      10: p = '{1, 4, 6, 9};
      11: p = '{1, 4, 7, 10};
      12: p = '{1, 4, 7, 10};
      13: p = '{2, 5, 8, 11};
      14: p = '{2, 5, 9, 12};
      15: p = '{2, 6, 9, 13};
      16: p = '{2, 6, 10, 14};
      17: p = '{2, 6, 11, 15};
      18: p = '{2, 7, 11, 16};
      19: p = '{2, 7, 12, 17};
      20: p = '{2, 7, 12, 17};
      21: p = '{3, 8, 13, 18};
      default: p = '{-1, -1, -1, -1};
    endcase
    return p[i];
  endfunction

  function automatic bit mem_exp(input int n, input int k);
    if (k < LAT || n < 1) return 1'b0;
    for (int i = 0; i < 4; i++) begin
      if (abs_pos(n, i) == ((k - 1) % n)) return 1'b1;
    end
    return 1'b0;
  endfunction

  task automatic check_all_zero(input string what);
    chk("R1", {what, " mem_f2s_en"}, 32'(mem_f2s_en), 0);
    chk("R1", {what, " mem_s2f_en"}, 32'(mem_s2f_en), 0);
    chk("R1", {what, " io2x_sync_en"}, 32'(io2x_sync_en), 0);
    chk("R1", {what, " io_sync_en"}, 32'(io_sync_en), 0);
    chk("R1", {what, " f2s_launch_q"}, 32'(f2s_launch_q), 0);
    chk("R1", {what, " s2f_capture_q"}, 32'(s2f_capture_q), 0);
  endtask

  // One cycle per iteration: sample after edge K, then drive new data.
  task automatic run_cycles(input int n, input int count, input string mtag,
                            output int pulses);
    bit e_mem, prev_seen;
    int q;
    pulses = 0;
    prev_seen = 1'b0;
    for (int c = 0; c < count; c++) begin
      @(negedge clk);
      K++;
      q = K - 1;
      e_mem = mem_exp(n, K);
      chk(mtag, "mem_f2s_en phase", 32'(mem_f2s_en), 32'(e_mem));
      chk("R5", "mem_s2f_en equals f2s", 32'(mem_s2f_en), 32'(mem_f2s_en));
      chk("R6", "io2x_sync_en phase", 32'(io2x_sync_en),
          32'((K >= LAT) && (q % 2 == 0)));
      chk("R6", "io_sync_en phase", 32'(io_sync_en),
          32'((K >= LAT) && (q % 4 == 0)));
      if (K < LAT) chk("R3", "enable during pipeline fill", 32'(mem_f2s_en), 0);
      chk("R9", "f2s_launch_q", 32'(f2s_launch_q), 32'(exp_launch));
      chk("R10", "s2f_capture_q", 32'(s2f_capture_q), 32'(exp_capt));
      if (prev_seen && mem_f2s_en) chk("R4", "adjacent pulses", 1, 0);
      prev_seen = mem_f2s_en;
      if (K >= LAT && K < LAT + 2 * n && mem_f2s_en) pulses++;
      f2s_din = DATA_W'(K * 37 + n);
      s2f_din = DATA_W'(K * 11 ^ 8'hA5);
      if (e_mem) begin
        exp_launch = f2s_din;
        exp_capt   = s2f_din;
      end
    end
  endtask

  task automatic release_ratio(input int n);
    @(negedge clk);
    align_rst_n = 1'b0;
    ratio_n     = 5'(n);
    f2s_din     = exp_launch;
    s2f_din     = exp_capt;
    @(negedge clk);
    chk("R11", "flush after aligned reset", 32'(mem_f2s_en | io2x_sync_en | io_sync_en), 0);
    @(negedge clk);
    align_rst_n = 1'b1;
    K = 0;
  endtask

  task automatic test_ratio(input int n);
    int pulses;
    release_ratio(n);
    run_cycles(n, LAT + 2 * n + 4, "R2", pulses);
    chk("R4", "pulses per two super-periods", 32'(pulses), 8);
  endtask

  task automatic test_ratio_change;
    int pulses;
    release_ratio(11);
    run_cycles(11, 30, "R2", pulses);
    ratio_n = 5'd9;
    run_cycles(11, 30, "R7", pulses);
    chk("R7", "pulses with ignored ratio change", 32'(pulses), 0);
    test_ratio(9);
  endtask

  task automatic test_invalid(input int n);
    int pulses;
    release_ratio(n);
    run_cycles(n, LAT + 20, "R8", pulses);
    chk("R8", "no pulses for invalid ratio", 32'(pulses), 0);
  endtask

  task automatic test_async_reset;
    int pulses;
    release_ratio(13);
    run_cycles(13, 20, "R2", pulses);
    #3;
    rst_n       = 1'b0;
    align_rst_n = 1'b0;
    #1;
    check_all_zero("mid-run reset");
    exp_launch = '0;
    exp_capt   = '0;
    f2s_din    = '0;
    s2f_din    = '0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_all_zero("after reset release");
    test_ratio(12);
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog R1 actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n       = 1'b0;
    align_rst_n = 1'b0;
    ratio_n     = '0;
    f2s_din     = '0;
    s2f_din     = '0;
    #55;
    check_all_zero("power-on reset");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_all_zero("idle after reset");

    test_ratio(11);
    test_ratio(9);
    test_ratio(13);
    test_ratio(8);
    test_ratio(21);
    test_ratio(10);
    test_ratio(14);
    test_ratio(16);
    test_ratio(20);
    test_ratio(17);
    test_ratio_change;
    test_invalid(5);
    test_invalid(22);
    test_async_reset;

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule